// File: doc/BRIEF.md
# Port Change-Detect Interrupt Generator

This block watches a parallel input port and pulls an active-low interrupt line whenever the port differs from a reference copy. The reference is the port value the host saw the last time it read the port. The input pins pass through a synchronizer first. Reading the port returns the synchronized pins, makes them the new reference and drops the interrupt. A separate bus-stop strobe also drops the interrupt. In compare mode the interrupt is a level comparison. If a pin returns to its reference level, the interrupt releases with no host action and the event is gone.

A mode input selects a sticky alternative. In sticky mode every synchronized bit that toggles sets a per-bit status flag. The flag stays set until the host reads the status register, so a short pulse that comes back to its starting level is still reported. A per-bit mask decides which bits may raise the interrupt. Masked bits still move the reference copy and the status flags.

The host interface is a read strobe with a two-bit register select, returning combinational read data, plus a write strobe that loads the mask.

Top module: `port_chg_irq`

## Requirements
- R1: After reset the interrupt output `irq_n_o` is high (deasserted), the mask and status read zero, and within three clocks of reset release the reference copy equals the synchronized pins. The interrupt stays deasserted throughout.
- R2: A pin change reaches the port read data after two rising edges. In compare mode it drives `irq_n_o` low after the third edge and not before.
- R3: In compare mode, a change of an unmasked synchronized bit that leaves the port different from the reference drives `irq_n_o` low. It stays low while that difference remains.
- R4: A port read (`rd_i`=1, `rd_sel_i`=0) returns the synchronized pins in the same cycle and loads them into the reference. In compare mode it releases `irq_n_o` at the next edge.
- R5: In compare mode, if the pins return to the reference value, `irq_n_o` returns high with no host access. The reference is left unchanged.
- R6: A one-cycle `stop_i` pulse releases `irq_n_o` at the next edge. In compare mode, an existing difference does not re-raise it; only a further input change does.
- R7: If a synchronized change appears in the same cycle as a port read, the change is absorbed into the reference and no interrupt follows.
- R8: In sticky mode (`sticky_i`=1), each synchronized bit that toggles sets its status flag. A pulse that returns to its original level keeps `irq_n_o` low until the status is read.
- R9: A status read (`rd_sel_i`=1) returns the flags and clears them. A toggle arriving in the same cycle as the read is kept and reported by the next status read.
- R10: A mask bit of 1 stops that bit from raising the interrupt, while it still updates the reference and the status flags. `wr_i` loads the mask from `wr_data_i`.
- R11: The register select encoding is 0 = port, 1 = status, 2 = mask, 3 = reference copy.
- R12: In sticky mode, a port read does not release `irq_n_o`. The interrupt is held while any unmasked status flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_i | input | 16 | Asynchronous input port |
| sticky_i | input | 1 | 0 = compare mode, 1 = sticky status mode |
| rd_i | input | 1 | Read strobe, one clock per access |
| rd_sel_i | input | 2 | Register select for reads |
| rd_data_o | output | 16 | Read data for the selected register |
| wr_i | input | 1 | Mask write strobe |
| wr_data_i | input | 16 | Mask write data (1 = masked) |
| stop_i | input | 1 | Bus-stop strobe, clears the interrupt |
| irq_n_o | output | 1 | Interrupt, active low |

## Verification
The critical collisions are a host read and a fresh synchronized input change that land in the same clock. The first case is a port read meeting a change at the compare. The second is a status read meeting a new toggle. The bench changes the pins exactly two edges before the strobe, so the change reaches the synchronizer output in the strobe cycle.

The two cases are judged differently. For the port read, the change must vanish into the reference, with the interrupt held high and the reference showing the new value. For the status read, the returned flags must exclude the new bit, while the flag register afterwards holds only that bit and the interrupt stays low.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

    // Host register select codes; the bench and the brief rely on this order.
    typedef enum logic [1:0] {
        SEL_PORT = 2'd0,
        SEL_STAT = 2'd1,
        SEL_MASK = 2'd2,
        SEL_SNAP = 2'd3
    } pcd_sel_e;

endpackage

// File: rtl/pcd_sync.sv
module pcd_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = pin_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign sync_o = stg_q[STAGES-1];

    AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stg_q[0] == $past(pin_i)); // R2

endmodule

// File: rtl/pcd_track.sv
module pcd_track #(
    parameter int W      = 16,
    parameter int SETTLE = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic         sticky_i,
    input  logic         rd_port_i,
    input  logic         rd_stat_i,
    output logic [W-1:0] chg_o,
    output logic [W-1:0] snap_o,
    output logic [W-1:0] status_o,
    output logic [W-1:0] status_nxt_o,
    output logic         settled_o
);

    localparam int CNT_W = $clog2(SETTLE + 1);

    typedef struct packed {
        logic [W-1:0]     snap;
        logic [W-1:0]     prev;
        logic [W-1:0]     status;
        logic [CNT_W-1:0] cnt;
    } track_t;

    track_t       d, q;
    logic         settled;
    logic [W-1:0] chg;

    assign settled = (q.cnt == CNT_W'(SETTLE));

    always_comb begin
        d   = q;
        chg = settled ? (sync_i ^ q.prev) : '0;

        d.prev = sync_i;
        if (!settled) begin
            d.cnt = q.cnt + CNT_W'(1);
        end

        // Reference copy follows the inputs until settled, then only on port reads.
        if (!settled || rd_port_i) begin
            d.snap = sync_i;
        end

        // Sticky flags: a status read replaces the flags with this cycle's toggles only.
        if (!settled || !sticky_i) begin
            d.status = '0;
        end else if (rd_stat_i) begin
            d.status = chg;
        end else begin
            d.status = q.status | chg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign chg_o        = chg;
    assign snap_o       = q.snap;
    assign status_o     = q.status;
    assign status_nxt_o = d.status;
    assign settled_o    = settled;

    AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_port_i |=> q.snap == $past(sync_i)); // R4

    AST_STATUS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && sticky_i && !rd_stat_i) |=>
            ((q.status & $past(q.status)) == $past(q.status))); // R8

endmodule

// File: rtl/pcd_irq.sv
module pcd_irq #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sticky_i,
    input  logic         settled_i,
    input  logic [W-1:0] chg_i,
    input  logic [W-1:0] diff_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] status_nxt_i,
    input  logic         clr_port_i,
    input  logic         stop_i,
    output logic         irq_n_o
);

    typedef struct packed {
        logic irq;
    } irq_t;

    irq_t d, q;
    logic live;
    logic pend_cmp;
    logic pend_stk;

    always_comb begin
        d        = q;
        live     = |(chg_i & ~mask_i);
        pend_cmp = |(diff_i & ~mask_i);
        pend_stk = |(status_nxt_i & ~mask_i);

        if (!settled_i || stop_i) begin
            d.irq = 1'b0;
        end else if (sticky_i) begin
            d.irq = live | (q.irq & pend_stk);
        end else if (clr_port_i) begin
            // Clear wins over a change arriving in the same cycle.
            d.irq = 1'b0;
        end else begin
            d.irq = (live & pend_cmp) | (q.irq & pend_cmp);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign irq_n_o = ~q.irq;

    AST_QUIET_UNSETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        !settled_i |-> !q.irq); // R1

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !q.irq); // R6

    AST_PORT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sticky_i && clr_port_i) |=> !q.irq); // R4

    AST_RAISE_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.irq) |-> $past(|(chg_i & ~mask_i))); // R10

endmodule

// File: rtl/port_chg_irq.sv
module port_chg_irq
    import pcd_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    input  logic         sticky_i,
    input  logic         rd_i,
    input  logic [1:0]   rd_sel_i,
    output logic [W-1:0] rd_data_o,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         stop_i,
    output logic         irq_n_o
);

    localparam int SETTLE = SYNC_STAGES + 1;

    typedef struct packed {
        logic [W-1:0] mask;
    } top_t;

    top_t         d, q;
    pcd_sel_e     sel;
    logic         rd_port;
    logic         rd_stat;
    logic [W-1:0] sync;
    logic [W-1:0] chg;
    logic [W-1:0] snap;
    logic [W-1:0] status;
    logic [W-1:0] status_nxt;
    logic         settled;

    assign sel     = pcd_sel_e'(rd_sel_i);
    assign rd_port = rd_i && (sel == SEL_PORT);
    assign rd_stat = rd_i && (sel == SEL_STAT);

    pcd_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pins_i),
        .sync_o (sync)
    );

    pcd_track #(.W(W), .SETTLE(SETTLE)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_i       (sync),
        .sticky_i     (sticky_i),
        .rd_port_i    (rd_port),
        .rd_stat_i    (rd_stat),
        .chg_o        (chg),
        .snap_o       (snap),
        .status_o     (status),
        .status_nxt_o (status_nxt),
        .settled_o    (settled)
    );

    pcd_irq #(.W(W)) u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .sticky_i     (sticky_i),
        .settled_i    (settled),
        .chg_i        (chg),
        .diff_i       (sync ^ snap),
        .mask_i       (q.mask),
        .status_nxt_i (status_nxt),
        .clr_port_i   (rd_port),
        .stop_i       (stop_i),
        .irq_n_o      (irq_n_o)
    );

    always_comb begin
        d = q;
        if (wr_i) begin
            d.mask = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_PORT: rd_data_o = sync;
            SEL_STAT: rd_data_o = status;
            SEL_MASK: rd_data_o = q.mask;
            SEL_SNAP: rd_data_o = snap;
            default:  rd_data_o = '0;
        endcase
    end

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> q.mask == $past(wr_data_i)); // R10

endmodule

// File: tb/tb_port_chg_irq.sv
module tb_port_chg_irq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pins = 16'hA5C3;
    logic        sticky = 1'b0;
    logic        rd = 1'b0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic        wr = 1'b0;
    logic [15:0] wr_data = '0;
    logic        stop = 1'b0;
    logic        irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    port_chg_irq dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_i    (pins),
        .sticky_i  (sticky),
        .rd_i      (rd),
        .rd_sel_i  (rd_sel),
        .rd_data_o (rd_data),
        .wr_i      (wr),
        .wr_data_i (wr_data),
        .stop_i    (stop),
        .irq_n_o   (irq_n)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [1:0] s, output logic [15:0] v);
        rd = 1'b0;
        rd_sel = s;
        #1;
        v = rd_data;
    endtask

    task automatic strobe(input logic [1:0] s, output logic [15:0] v);
        rd = 1'b1;
        rd_sel = s;
        #1;
        v = rd_data;
        tick(1);
        rd = 1'b0;
        #1;
    endtask

    task automatic set_mask(input logic [15:0] m);
        wr = 1'b1;
        wr_data = m;
        tick(1);
        wr = 1'b0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        tick(3);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            chk("R1 irq idle after reset", {15'd0, irq_n}, 16'd1);
            tick(1);
        end
        peek(2'd3, v); chk("R1 R11 reference equals pins", v, 16'hA5C3);
        peek(2'd0, v); chk("R11 port read", v, 16'hA5C3);
        peek(2'd2, v); chk("R1 R11 mask zero", v, 16'h0000);
        peek(2'd1, v); chk("R1 R11 status zero", v, 16'h0000);
    endtask

    task automatic t_basic;
        logic [15:0] v;
        pins = pins ^ 16'h0010;
        tick(2);
        chk("R2 irq not yet after two edges", {15'd0, irq_n}, 16'd1);
        peek(2'd0, v); chk("R2 port shows change", v, 16'hA5D3);
        tick(1);
        chk("R3 irq low on change", {15'd0, irq_n}, 16'd0);
        strobe(2'd0, v);
        chk("R4 port read data", v, 16'hA5D3);
        chk("R4 irq released by port read", {15'd0, irq_n}, 16'd1);
        peek(2'd3, v); chk("R4 reference loaded", v, 16'hA5D3);
    endtask

    task automatic t_return;
        logic [15:0] v;
        pins = pins ^ 16'h0100;
        tick(3);
        chk("R5 irq low on change", {15'd0, irq_n}, 16'd0);
        pins = pins ^ 16'h0100;
        tick(3);
        chk("R5 irq released on return", {15'd0, irq_n}, 16'd1);
        peek(2'd3, v); chk("R5 reference unchanged", v, 16'hA5D3);
    endtask

    task automatic t_stop;
        logic [15:0] v;
        pins = pins ^ 16'h0001;
        tick(3);
        chk("R6 irq low before stop", {15'd0, irq_n}, 16'd0);
        stop = 1'b1;
        tick(1);
        stop = 1'b0;
        chk("R6 stop releases irq", {15'd0, irq_n}, 16'd1);
        tick(4);
        chk("R6 irq stays released", {15'd0, irq_n}, 16'd1);
        pins = pins ^ 16'h0002;
        tick(3);
        chk("R6 new change re-raises", {15'd0, irq_n}, 16'd0);
        strobe(2'd0, v);
        chk("R6 port read clears", {15'd0, irq_n}, 16'd1);
    endtask

    task automatic t_lost;
        logic [15:0] v;
        pins = pins ^ 16'h0400;
        tick(2);
        strobe(2'd0, v);
        chk("R7 read returns new value", v, pins);
        chk("R7 coincident change gives no irq", {15'd0, irq_n}, 16'd1);
        tick(3);
        chk("R7 irq still idle", {15'd0, irq_n}, 16'd1);
        peek(2'd3, v); chk("R7 reference absorbed change", v, pins);
    endtask

    task automatic t_mask_cmp;
        logic [15:0] v;
        set_mask(16'h0F00);
        peek(2'd2, v); chk("R10 R11 mask readback", v, 16'h0F00);
        pins = pins ^ 16'h0200;
        tick(4);
        chk("R10 masked change no irq", {15'd0, irq_n}, 16'd1);
        strobe(2'd0, v);
        peek(2'd3, v); chk("R10 masked bit updates reference", v, pins);
        pins = pins ^ 16'h0004;
        tick(3);
        chk("R10 unmasked bit raises", {15'd0, irq_n}, 16'd0);
        strobe(2'd0, v);
        set_mask(16'h0000);
    endtask

    task automatic t_sticky_pulse;
        logic [15:0] v;
        sticky = 1'b1;
        tick(2);
        pins = pins ^ 16'h0008;
        tick(1);
        pins = pins ^ 16'h0008;
        tick(5);
        chk("R8 pulse keeps irq low", {15'd0, irq_n}, 16'd0);
        peek(2'd1, v); chk("R8 status records pulse", v, 16'h0008);
        strobe(2'd0, v);
        chk("R12 port read keeps irq", {15'd0, irq_n}, 16'd0);
        strobe(2'd1, v);
        chk("R9 status read data", v, 16'h0008);
        chk("R9 irq released after status read", {15'd0, irq_n}, 16'd1);
        peek(2'd1, v); chk("R9 status cleared", v, 16'h0000);
    endtask

    task automatic t_sticky_race;
        logic [15:0] v;
        pins = pins ^ 16'h0001;
        tick(3);
        peek(2'd1, v); chk("R8 status bit0", v, 16'h0001);
        pins = pins ^ 16'h0002;
        tick(2);
        strobe(2'd1, v);
        chk("R9 read excludes coincident bit", v, 16'h0001);
        peek(2'd1, v); chk("R9 coincident bit kept", v, 16'h0002);
        chk("R9 irq held by kept bit", {15'd0, irq_n}, 16'd0);
        strobe(2'd1, v);
        chk("R9 next read reports kept bit", v, 16'h0002);
        chk("R9 irq released", {15'd0, irq_n}, 16'd1);
    endtask

    task automatic t_sticky_mask;
        logic [15:0] v;
        set_mask(16'h0020);
        pins = pins ^ 16'h0020;
        tick(4);
        peek(2'd1, v); chk("R10 masked bit sets status", v, 16'h0020);
        chk("R10 masked status no irq", {15'd0, irq_n}, 16'd1);
        strobe(2'd1, v);
        set_mask(16'h0000);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_return();
        t_stop();
        t_lost();
        t_mask_cmp();
        t_sticky_pulse();
        t_sticky_race();
        t_sticky_mask();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule